// File: doc/BRIEF.md
# Host-Port Interrupt Register Block

This block is a small memory-mapped peripheral on a 32-bit register bus. It keeps two descriptor words, a control word, an interrupt status word and one shared software-interrupt word, and it drives a single level-sensitive interrupt line toward the system interrupt controller. The line is not a masked OR of status bits. Writes that carry particular bits to particular registers set or clear it, and it holds its level between such writes.

Software reaches the block through a single-cycle bus with a 12-bit byte address. The address covers a 4 KiB window, and only aligned full-word accesses are decoded. Read data is registered, so it appears one cycle after the read strobe. A one-cycle pulse flags any access to an offset that holds no register. Reset is asynchronous and active low, and its release is synchronous.

Top module: `hostport_irq_regs`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every stored word, the software-interrupt word and `irq_out` are zero, and `bus_rdata` and `bus_unmapped` are zero.
- R2: A write to offset 0x028 (word A) or 0x02C (word B) stores all 32 bits. A read of either offset returns the stored word on `bus_rdata` in the cycle after the read strobe. In any cycle that follows a cycle without a read strobe, `bus_rdata` is zero.
- R3: A write to word B with bit 29 set drives `irq_out` high from the next cycle. A write to word A, or to word B with bit 29 clear, leaves `irq_out` unchanged.
- R4: A write to the control word at 0x04C stores the value, and drives `irq_out` low if bit 16 is set. A read of the control word returns the stored value with bit 17 forced to 1.
- R5: A write to the status word at 0x050 stores the written value. If bit 16 or bit 29 of that value is set, `irq_out` goes low. A read returns the stored value unchanged.
- R6: A write to 0x1F0 ORs the written bits into the software-interrupt word and drives `irq_out` high. A read of either 0x1F0 or 0x1F4 returns the software-interrupt word.
- R7: A write to 0x1F4 clears the written bits in the software-interrupt word and drives `irq_out` low.
- R8: `irq_out` changes only in the cycle after a write strobe. A write that meets no set or clear condition leaves the line unchanged. Clear has priority over set.
- R9: An offset that is not one of the six above, or that is not a multiple of 4, is unmapped. A read of an unmapped offset returns zero, and a write to one changes no state. Any read or write to an unmapped offset raises `bus_unmapped` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, little-endian word |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_unmapped | output | 1 | One-cycle pulse after an access to an unmapped offset |
| irq_out | output | 1 | Level interrupt line |

## Verification
The embedded assertions check several rules on every cycle. The interrupt line stays put when no write strobe is present. Each clearing write pulls the line low, and each raising write with no clear pulls it high. Read data is zero after idle cycles and after unmapped reads, and bit 17 reads back set after any control read. The bench scenarios are the only way to show the things a single-cycle property cannot follow: stored values that survive across many later writes, bits accumulating and clearing in the shared software word, the full-word contents of each read, and that unaligned or unmapped writes leave every register unchanged.

// File: rtl/hpirq_pkg.sv
package hpirq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_WORD_A = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_WORD_B = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h050;
  localparam logic [ADDR_W-1:0] OFS_SW_SET = 12'h1F0;
  localparam logic [ADDR_W-1:0] OFS_SW_CLR = 12'h1F4;

  localparam int RAISE_BIT_B    = 29;
  localparam int CTRL_DROP_BIT  = 16;
  localparam int CTRL_FIXED_BIT = 17;
  localparam int STAT_DROP_LO   = 16;
  localparam int STAT_DROP_HI   = 29;

  localparam int NUM_PLAIN = 4;

  typedef struct packed {
    logic word_a;
    logic word_b;
    logic ctrl;
    logic stat;
    logic sw_set;
    logic sw_clr;
  } hit_t;
endpackage

// File: rtl/hpirq_decode.sv
module hpirq_decode
  import hpirq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output hit_t          hit,
  output logic          mapped
);
  logic aligned;

  always_comb begin
    aligned    = (addr[1:0] == 2'b00);
    hit        = '0;
    hit.word_a = aligned && (addr == OFS_WORD_A);
    hit.word_b = aligned && (addr == OFS_WORD_B);
    hit.ctrl   = aligned && (addr == OFS_CTRL);
    hit.stat   = aligned && (addr == OFS_STAT);
    hit.sw_set = aligned && (addr == OFS_SW_SET);
    hit.sw_clr = aligned && (addr == OFS_SW_CLR);
    mapped     = |hit;
  end
endmodule

// File: rtl/hpirq_regs.sv
module hpirq_regs
  import hpirq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  hit_t          hit,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] word_a_q,
  output logic [DW-1:0] word_b_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] sw_q
);
  logic [NUM_PLAIN-1:0] plain_sel;
  logic [DW-1:0]        plain_q [NUM_PLAIN];
  logic [DW-1:0]        sw_d;
  logic                 sw_en;

  assign plain_sel = {hit.stat, hit.ctrl, hit.word_b, hit.word_a};

  // Plain storage words: each has its own clock enable
  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    logic          en;
    logic [DW-1:0] d;

    always_comb begin
      en = wr_en && plain_sel[g];
      d  = en ? wdata : plain_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) plain_q[g] <= '0;
      else if (en) plain_q[g] <= d;
    end
  end

  // Shared software-interrupt word: set and clear views
  always_comb begin
    sw_en = wr_en && (hit.sw_set || hit.sw_clr);
    sw_d  = sw_q;
    if (hit.sw_set) sw_d = sw_q | wdata;
    else if (hit.sw_clr) sw_d = sw_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else if (sw_en) sw_q <= sw_d;
  end

  assign word_a_q = plain_q[0];
  assign word_b_q = plain_q[1];
  assign ctrl_q   = plain_q[2];
  assign stat_q   = plain_q[3];

  AST_SW_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit.sw_set) |=> ((sw_q & $past(wdata)) == $past(wdata))) // R6
    else $error("sw set lost bits");
  AST_SW_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit.sw_clr) |=> ((sw_q & $past(wdata)) == '0)) // R7
    else $error("sw clear kept bits");
  AST_NO_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(word_a_q) && $stable(word_b_q) && $stable(ctrl_q)
                && $stable(stat_q) && $stable(sw_q))) // R9
    else $error("storage changed without write");
endmodule

// File: rtl/hpirq_line.sv
module hpirq_line
  import hpirq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  hit_t          hit,
  input  logic [DW-1:0] wdata,
  output logic          irq_q
);
  logic set_req, clr_req, irq_d, irq_en;

  always_comb begin
    set_req = wr_en && ((hit.word_b && wdata[RAISE_BIT_B]) || hit.sw_set);
    clr_req = wr_en && ((hit.ctrl && wdata[CTRL_DROP_BIT])
                     || (hit.stat && (wdata[STAT_DROP_LO] || wdata[STAT_DROP_HI]))
                     || hit.sw_clr);
    irq_en  = set_req || clr_req;
    irq_d   = clr_req ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(irq_q)) // R8
    else $error("irq moved without write");
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !irq_q) // R8
    else $error("clear did not drop irq");
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !clr_req) |=> irq_q) // R3
    else $error("set did not raise irq");
endmodule

// File: rtl/hpirq_readmux.sv
module hpirq_readmux
  import hpirq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  hit_t          hit,
  input  logic          mapped,
  input  logic [DW-1:0] word_a_q,
  input  logic [DW-1:0] word_b_q,
  input  logic [DW-1:0] ctrl_q,
  input  logic [DW-1:0] stat_q,
  input  logic [DW-1:0] sw_q,
  output logic [DW-1:0] rdata_q,
  output logic          unmapped_q
);
  localparam logic [DW-1:0] CTRL_FIXED = DW'(1) << CTRL_FIXED_BIT;

  logic [DW-1:0] rdata_d;
  logic          unmapped_d;

  always_comb begin
    rdata_d = '0;
    if (rd_en) begin
      if (hit.word_a) rdata_d = word_a_q;
      if (hit.word_b) rdata_d = word_b_q;
      if (hit.ctrl)   rdata_d = ctrl_q | CTRL_FIXED;
      if (hit.stat)   rdata_d = stat_q;
      if (hit.sw_set || hit.sw_clr) rdata_d = sw_q;
    end
    unmapped_d = (rd_en || wr_en) && !mapped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      unmapped_q <= 1'b0;
    end else begin
      rdata_q    <= rdata_d;
      unmapped_q <= unmapped_d;
    end
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata_q == '0)) // R2
    else $error("read data not zero after idle");
  AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit.ctrl) |=> rdata_q[CTRL_FIXED_BIT]) // R4
    else $error("control fixed bit missing");
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata_q == '0 && unmapped_q)) // R9
    else $error("unmapped read wrong");
endmodule

// File: rtl/hostport_irq_regs.sv
module hostport_irq_regs
  import hpirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_unmapped,
  output logic              irq_out
);
  hit_t              hit;
  logic              mapped;
  logic [DATA_W-1:0] word_a_q, word_b_q, ctrl_q, stat_q, sw_q;

  hpirq_decode #(.AW(ADDR_W)) u_decode (
    .addr   (bus_addr),
    .hit    (hit),
    .mapped (mapped)
  );

  hpirq_regs #(.DW(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .hit      (hit),
    .wdata    (bus_wdata),
    .word_a_q (word_a_q),
    .word_b_q (word_b_q),
    .ctrl_q   (ctrl_q),
    .stat_q   (stat_q),
    .sw_q     (sw_q)
  );

  hpirq_line #(.DW(DATA_W)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_wr),
    .hit   (hit),
    .wdata (bus_wdata),
    .irq_q (irq_out)
  );

  hpirq_readmux #(.DW(DATA_W)) u_readmux (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (bus_rd),
    .wr_en      (bus_wr),
    .hit        (hit),
    .mapped     (mapped),
    .word_a_q   (word_a_q),
    .word_b_q   (word_b_q),
    .ctrl_q     (ctrl_q),
    .stat_q     (stat_q),
    .sw_q       (sw_q),
    .rdata_q    (bus_rdata),
    .unmapped_q (bus_unmapped)
  );

  AST_STAT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit.stat && (bus_wdata[STAT_DROP_LO] || bus_wdata[STAT_DROP_HI]))
      |=> !irq_out) // R5
    else $error("status write did not drop irq");
  AST_CTRL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit.ctrl && bus_wdata[CTRL_DROP_BIT]) |=> !irq_out) // R4
    else $error("control write did not drop irq");
  AST_UNMAPPED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !bus_wr) |=> !bus_unmapped) // R9
    else $error("unmapped pulse without access");
endmodule

// File: tb/hostport_irq_regs_bench.sv
module hostport_irq_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        bus_unmapped;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_a, m_b, m_ctrl, m_stat, m_sw;
  logic        m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostport_irq_regs u_hostport_irq_regs (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rd,
    .bus_rdata, .bus_unmapped, .irq_out
  );

  function automatic bit is_mapped(input logic [11:0] a);
    return a == 12'h028 || a == 12'h02C || a == 12'h04C ||
           a == 12'h050 || a == 12'h1F0 || a == 12'h1F4;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h028: return m_a;
      12'h02C: return m_b;
      12'h04C: return m_ctrl | 32'h0002_0000;
      12'h050: return m_stat;
      12'h1F0, 12'h1F4: return m_sw;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    bit s = 0, c = 0;
    case (a)
      12'h028: m_a = d;
      12'h02C: begin m_b = d; s = d[29]; end
      12'h04C: begin m_ctrl = d; c = d[16]; end
      12'h050: begin m_stat = d; c = d[16] | d[29]; end
      12'h1F0: begin m_sw = m_sw | d; s = 1; end
      12'h1F4: begin m_sw = m_sw & ~d; c = 1; end
      default: ;
    endcase
    if (c) m_irq = 0;
    else if (s) m_irq = 1;
  endtask

  // one bus cycle; kind 0 idle, 1 write, 2 read. Called at a negedge.
  task automatic access(input int kind, input logic [11:0] a, input logic [31:0] d, input string req);
    logic [31:0] er;
    bit          eu;
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = (kind == 1);
    bus_rd    = (kind == 2);
    er = (kind == 2) ? exp_read(a) : 32'h0;
    eu = (kind != 0) && !is_mapped(a);
    if (kind == 1) model_write(a, d);
    @(negedge clk);
    bus_wr = 0;
    bus_rd = 0;
    check({req, " rdata"}, bus_rdata, er);
    check({req, " unmapped"}, {31'h0, bus_unmapped}, {31'h0, eu});
    check({req, " irq"}, {31'h0, irq_out}, {31'h0, m_irq});
  endtask

  task automatic read_all(input string req);
    access(2, 12'h028, 0, req);
    access(2, 12'h02C, 0, req);
    access(2, 12'h04C, 0, req);
    access(2, 12'h050, 0, req);
    access(2, 12'h1F0, 0, req);
    access(2, 12'h1F4, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [6];
    addrs = '{12'h028, 12'h02C, 12'h04C, 12'h050, 12'h1F0, 12'h1F4};
    void'($urandom(32'h5EED_1234));
    m_a = 0; m_b = 0; m_ctrl = 0; m_stat = 0; m_sw = 0; m_irq = 0;
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    // R1: reset values during reset
    check("R1 rdata in reset", bus_rdata, 0);
    check("R1 irq in reset", {31'h0, irq_out}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 unmapped after reset", {31'h0, bus_unmapped}, 0);
    read_all("R1 reset readback");

    // R2 storage and idle read data
    access(1, 12'h028, 32'hDEAD_BEEF, "R2 write A");
    access(1, 12'h02C, 32'h1234_5678, "R2 write B no bit29");
    access(2, 12'h028, 0, "R2 read A");
    access(2, 12'h02C, 0, "R2 read B");
    access(0, 12'h028, 0, "R2 idle zero");
    // R3 raise via B bit29, A has no side effect
    access(1, 12'h028, 32'hFFFF_FFFF, "R3 A no irq");
    access(1, 12'h02C, 32'h2000_0000, "R3 B raises");
    access(1, 12'h02C, 32'h0000_0001, "R3 B holds");
    // R4 control
    access(1, 12'h04C, 32'h0000_0005, "R4 ctrl no drop");
    access(2, 12'h04C, 0, "R4 ctrl bit17 forced");
    access(1, 12'h04C, 32'h0001_0000, "R4 ctrl drop");
    // R5 status
    access(1, 12'h02C, 32'h2000_0000, "R5 re-raise");
    access(1, 12'h050, 32'h0000_00FF, "R5 stat no drop");
    access(1, 12'h050, 32'h2000_0000, "R5 stat drop hi");
    access(1, 12'h1F0, 32'h0, "R6 raise empty");
    access(1, 12'h050, 32'h0001_0000, "R5 stat drop lo");
    access(2, 12'h050, 0, "R5 stat read");
    // R6/R7 software word
    access(1, 12'h1F0, 32'h0000_00F0, "R6 set");
    access(1, 12'h1F0, 32'h0000_0003, "R6 set accumulate");
    access(2, 12'h1F4, 0, "R6 read via clr");
    access(1, 12'h1F4, 32'h0000_0010, "R7 clear");
    access(2, 12'h1F0, 0, "R7 read via set");
    // R8 non-trigger write keeps line
    access(1, 12'h1F0, 32'h0, "R8 raise");
    access(1, 12'h028, 32'h0, "R8 hold on A");
    access(1, 12'h123, 32'hFFFF_FFFF, "R8 hold on unmapped");
    // R9 unmapped and unaligned
    access(1, 12'h029, 32'hFFFF_FFFF, "R9 unaligned write");
    access(1, 12'h4F4, 32'hFFFF_FFFF, "R9 unmapped write");
    access(2, 12'h02E, 0, "R9 unaligned read");
    access(2, 12'hFFC, 0, "R9 unmapped read");
    read_all("R9 state untouched");

    // random mix, checked by the model
    for (int i = 0; i < N_RANDOM; i++) begin
      int          kind;
      logic [11:0] a;
      logic [31:0] d;
      kind = $urandom_range(0, 2);
      if ($urandom_range(0, 7) == 0) a = 12'($urandom);
      else a = addrs[$urandom_range(0, 5)];
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d = d & 32'hDFFE_FFFF;
      access(kind, a, d, "R8 random");
    end
    read_all("R2 final readback");

    // R1: reset mid-run clears everything
    access(1, 12'h1F0, 32'hFFFF_FFFF, "R1 before reset");
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    m_a = 0; m_b = 0; m_ctrl = 0; m_stat = 0; m_sw = 0; m_irq = 0;
    @(negedge clk);
    check("R1 irq after reset", {31'h0, irq_out}, 0);
    read_all("R1 after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule